// File: doc/BRIEF.md
# Processor Interrupt Acceptance Unit

This unit sits beside a processor core's control path. Every cycle it decides whether the core should accept a hardware interrupt at the current instruction boundary. It reports that decision as a one-cycle take pulse. A separate work-pending flag tells the core's idle or sleep logic that some request exists, whether or not that request is masked.

One of two request schemes is chosen at elaboration through a parameter. In internal mode, a bank of level-sensitive request lines is copied every cycle into a pending register. The pending register is gated by an enable register that software writes and by the global interrupt-enable status bit.

In external mode, a single request port carries three things: a priority level, a target register-set number and a non-maskable flag. That request is compared with the current status fields, which are the global enable, the NMI-in-progress bit, the current interrupt level, the current register set and the register-set interrupt-enable bit. Vector selection, register-set switching and exception entry belong to the core and are not part of this unit.

Top module: `irq_accept_unit`

## Requirements
- R1: In internal mode, bit n of `pending` equals the level of `irq_lines[n]` sampled at the previous rising clock edge, for every one of the NUM_LINES bits.
- R2: In internal mode, a take is produced only if `st_pie` is 1 and the bitwise AND of `pending` and the enable register has at least one bit set. This holds for the highest line index as well as lower ones.
- R3: The enable register loads `enable_wdata` on a clock edge where `enable_we` is 1. It keeps its value when `enable_we` is 0, and any data presented with `enable_we` at 0 is ignored.
- R4: In external mode, a request with `ext_nmi`=1 is taken whenever `st_nmi` is 0, whatever `st_pie` and the levels are. It is never taken while `st_nmi` is 1.
- R5: In external mode, a request with `ext_nmi`=0 is never taken while `st_pie` is 0.
- R6: In external mode, a request with `ext_nmi`=0 is taken only if `ext_level` is strictly greater than `st_il`. Equal or lower levels are rejected.
- R7: In external mode, once R5 and R6 pass, a request whose `ext_set` differs from `st_crs` is taken whatever the value of `st_rsie`.
- R8: In external mode, once R5 and R6 pass, a request whose `ext_set` equals `st_crs` is taken only if `st_rsie` is 1.
- R9: `work_pending` is 1 whenever any request is active in the selected mode, even a fully masked one. That means any line set in `pending` in internal mode, or `ext_valid` held in external mode. It is 0 otherwise.
- R10: `take_irq` rises only in the cycle after an edge at which `at_boundary` was 1. It is never high in two consecutive cycles. Request inputs reach `take_irq` and `work_pending` two clock edges after they are applied, and status inputs and `at_boundary` reach them one edge after.
- R11: While `rst` is high, `take_irq`, `work_pending` and `pending` are 0, and the enable register is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | NUM_LINES | Level-sensitive request lines (internal mode) |
| enable_we | input | 1 | Enable register write strobe (internal mode) |
| enable_wdata | input | NUM_LINES | Enable register write data |
| ext_valid | input | 1 | External request active |
| ext_nmi | input | 1 | External request is non-maskable |
| ext_level | input | 6 | External requested level |
| ext_set | input | 6 | External requested register set |
| st_pie | input | 1 | Status: global interrupt enable |
| st_rsie | input | 1 | Status: register-set interrupt enable |
| st_nmi | input | 1 | Status: non-maskable handler in progress |
| st_il | input | 6 | Status: current interrupt level |
| st_crs | input | 6 | Status: current register set |
| at_boundary | input | 1 | Core is at an instruction boundary |
| pending | output | NUM_LINES | Mirrored request lines (0 in external mode) |
| take_irq | output | 1 | One-cycle take pulse |
| work_pending | output | 1 | Some request is active, masked or not |

## Verification
The hardest corners to reach from the ports are in external mode, where the outcome turns on the order in which the checks are applied. One case is a level exactly equal to the current level with a mismatching register set, which must still be rejected. Another is a non-maskable request arriving while global enable is off. The stimulus reaches these by holding the request steady and changing one status field at a time, so that each gate is the only thing that differs between a take and a reject.

The no-back-to-back rule is covered by holding the boundary strobe high for three cycles against a standing request, which should give a take, then a gap, then a take.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  localparam int LVL_W = 6;

  typedef struct packed {
    logic             pie;
    logic             rsie;
    logic             nmi;
    logic [LVL_W-1:0] il;
    logic [LVL_W-1:0] crs;
  } irq_status_t;

  typedef struct packed {
    logic             valid;
    logic             nmi;
    logic [LVL_W-1:0] level;
    logic [LVL_W-1:0] rset;
  } ext_req_t;
endpackage

// File: rtl/irq_int_path.sv
module irq_int_path #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] lines,
  input  logic                 we,
  input  logic [NUM_LINES-1:0] wdata,
  input  logic                 pie,
  output logic [NUM_LINES-1:0] pend,
  output logic                 decide,
  output logic                 busy
);
  logic [NUM_LINES-1:0] pend_q;
  logic [NUM_LINES-1:0] en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= lines;
      if (we) en_q <= wdata;
    end
  end

  assign pend   = pend_q;
  assign decide = pie & (|(pend_q & en_q));
  assign busy   = |pend_q;

  // R1: pending mirrors the request lines one edge later
  assert_pend_follows_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pend_q == $past(lines));

  // R3: enable register is untouched without a write strobe
  assert_enable_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(we)) |-> $stable(en_q));
endmodule

// File: rtl/irq_ext_path.sv
module irq_ext_path
  import irq_accept_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  ext_req_t    req,
  input  irq_status_t st,
  output ext_req_t    held,
  output logic        decide,
  output logic        busy
);
  ext_req_t req_q;
  logic     lvl_ok;
  logic     set_differs;

  always_ff @(posedge clk) begin
    if (rst) req_q <= '0;
    else     req_q <= req;
  end

  assign lvl_ok      = req_q.level > st.il;
  assign set_differs = req_q.rset != st.crs;

  always_comb begin
    decide = 1'b0;
    if (req_q.valid) begin
      if (req_q.nmi)          decide = !st.nmi;
      else if (!st.pie)       decide = 1'b0;
      else if (!lvl_ok)       decide = 1'b0;
      else if (set_differs)   decide = 1'b1;
      else                    decide = st.rsie;
    end
  end

  assign held = req_q;
  assign busy = req_q.valid;
endmodule

// File: rtl/irq_take_gate.sv
module irq_take_gate (
  input  logic clk,
  input  logic rst,
  input  logic decide,
  input  logic busy,
  input  logic at_boundary,
  output logic take_q,
  output logic work_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      take_q <= 1'b0;
      work_q <= 1'b0;
    end else begin
      take_q <= decide & at_boundary & ~take_q;
      work_q <= busy;
    end
  end

  // R10: a take follows a boundary edge
  assert_take_boundary_R10: assert property (@(posedge clk) disable iff (rst)
    take_q |-> $past(at_boundary));

  // R10: no two takes back to back
  assert_take_single_R10: assert property (@(posedge clk) disable iff (rst)
    take_q |=> !take_q);
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
  import irq_accept_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter bit EXT_MODE  = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic                 enable_we,
  input  logic [NUM_LINES-1:0] enable_wdata,
  input  logic                 ext_valid,
  input  logic                 ext_nmi,
  input  logic [LVL_W-1:0]     ext_level,
  input  logic [LVL_W-1:0]     ext_set,
  input  logic                 st_pie,
  input  logic                 st_rsie,
  input  logic                 st_nmi,
  input  logic [LVL_W-1:0]     st_il,
  input  logic [LVL_W-1:0]     st_crs,
  input  logic                 at_boundary,
  output logic [NUM_LINES-1:0] pending,
  output logic                 take_irq,
  output logic                 work_pending
);
  irq_status_t st_w;
  ext_req_t    req_w;
  logic        decide_w;
  logic        busy_w;

  assign st_w  = '{pie: st_pie, rsie: st_rsie, nmi: st_nmi, il: st_il, crs: st_crs};
  assign req_w = '{valid: ext_valid, nmi: ext_nmi, level: ext_level, rset: ext_set};

  generate
    if (EXT_MODE) begin : g_ext
      ext_req_t held_w;
      logic     unused_int;

      assign unused_int = ^{irq_lines, enable_we, enable_wdata};
      assign pending    = '0;

      irq_ext_path u_ext (
        .clk    (clk),
        .rst    (rst),
        .req    (req_w),
        .st     (st_w),
        .held   (held_w),
        .decide (decide_w),
        .busy   (busy_w)
      );

      // R4: non-maskable take only outside an NMI handler
      assert_nmi_gate_R4: assert property (@(posedge clk) disable iff (rst)
        (take_irq && $past(held_w.nmi)) |-> !$past(st_nmi));
      // R5: maskable take needs global enable
      assert_pie_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (take_irq && !$past(held_w.nmi)) |-> $past(st_pie));
      // R6: maskable take needs a strictly higher level
      assert_level_gate_R6: assert property (@(posedge clk) disable iff (rst)
        (take_irq && !$past(held_w.nmi)) |-> ($past(held_w.level) > $past(st_il)));
      // R8: same-set take needs the set interrupt enable
      assert_same_set_R8: assert property (@(posedge clk) disable iff (rst)
        (take_irq && !$past(held_w.nmi) && ($past(held_w.rset) == $past(st_crs)))
          |-> $past(st_rsie));
      // R9: work flag follows the held request
      assert_work_ext_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> work_pending == $past(held_w.valid));
    end else begin : g_int
      logic unused_ext;

      assign unused_ext = ^{req_w, st_w.rsie, st_w.nmi, st_w.il, st_w.crs};

      irq_int_path #(.NUM_LINES(NUM_LINES)) u_int (
        .clk    (clk),
        .rst    (rst),
        .lines  (irq_lines),
        .we     (enable_we),
        .wdata  (enable_wdata),
        .pie    (st_pie),
        .pend   (pending),
        .decide (decide_w),
        .busy   (busy_w)
      );

      // R2: internal take needs global enable and an enabled pending line
      assert_int_gate_R2: assert property (@(posedge clk) disable iff (rst)
        take_irq |-> ($past(st_pie) && $past(|pending)));
      // R9: work flag follows any pending line
      assert_work_int_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> work_pending == $past(|pending));
    end
  endgenerate

  irq_take_gate u_gate (
    .clk         (clk),
    .rst         (rst),
    .decide      (decide_w),
    .busy        (busy_w),
    .at_boundary (at_boundary),
    .take_q      (take_irq),
    .work_q      (work_pending)
  );
endmodule

// File: tb/sim_irq_accept_unit.sv
module sim_irq_accept_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_lines = '0;
  logic        enable_we = 1'b0;
  logic [31:0] enable_wdata = '0;
  logic        ext_valid = 1'b0, ext_nmi = 1'b0;
  logic [5:0]  ext_level = '0, ext_set = '0;
  logic        st_pie = 1'b0, st_rsie = 1'b0, st_nmi = 1'b0;
  logic [5:0]  st_il = '0, st_crs = '0;
  logic        at_boundary = 1'b0;
  logic [31:0] pend0, pend1;
  logic        take0, work0, take1, work1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit          inst;
    bit          take;
    bit          work;
    bit          chk_pend;
    logic [31:0] pend;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  irq_accept_unit #(.NUM_LINES(32), .EXT_MODE(1'b0)) u0 (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .enable_we(enable_we),
    .enable_wdata(enable_wdata), .ext_valid(ext_valid), .ext_nmi(ext_nmi),
    .ext_level(ext_level), .ext_set(ext_set), .st_pie(st_pie), .st_rsie(st_rsie),
    .st_nmi(st_nmi), .st_il(st_il), .st_crs(st_crs), .at_boundary(at_boundary),
    .pending(pend0), .take_irq(take0), .work_pending(work0));

  irq_accept_unit #(.NUM_LINES(32), .EXT_MODE(1'b1)) u1 (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .enable_we(enable_we),
    .enable_wdata(enable_wdata), .ext_valid(ext_valid), .ext_nmi(ext_nmi),
    .ext_level(ext_level), .ext_set(ext_set), .st_pie(st_pie), .st_rsie(st_rsie),
    .st_nmi(st_nmi), .st_il(st_il), .st_crs(st_crs), .at_boundary(at_boundary),
    .pending(pend1), .take_irq(take1), .work_pending(work1));

  // monitor: compares queued expectations at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        exp_t e;
        bit at, aw;
        logic [31:0] ap;
        e  = sb.pop_front();
        at = e.inst ? take1 : take0;
        aw = e.inst ? work1 : work0;
        ap = e.inst ? pend1 : pend0;
        checks++;
        if (at !== e.take || aw !== e.work || (e.chk_pend && ap !== e.pend)) begin
          errors++;
          $display("FAIL %s: actual take=%0b work=%0b pend=%h expected take=%0b work=%0b pend=%h",
                   e.tag, at, aw, ap, e.take, e.work, e.pend);
        end
      end
    end
  end

  task automatic push(bit inst, bit tk, bit wk, bit cp, logic [31:0] p, string tag);
    exp_t e;
    e.inst = inst; e.take = tk; e.work = wk; e.chk_pend = cp; e.pend = p; e.tag = tag;
    sb.push_back(e);
  endtask

  // wait for a request to settle (two edges), then open one boundary cycle
  task automatic try_take(bit inst, bit tk, bit wk, string tag);
    repeat (2) @(posedge clk);
    @(negedge clk);
    at_boundary = 1'b1;
    @(posedge clk);
    push(inst, tk, wk, 1'b0, '0, tag);
    @(negedge clk);
    at_boundary = 1'b0;
  endtask

  task automatic write_en(bit we, logic [31:0] d);
    @(negedge clk);
    enable_we = we; enable_wdata = d;
    @(negedge clk);
    enable_we = 1'b0; enable_wdata = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    push(1'b0, 1'b0, 1'b0, 1'b1, 32'h0, "R11 reset internal");
    push(1'b1, 1'b0, 1'b0, 1'b0, 32'h0, "R11 reset external");
    @(negedge clk);
    rst = 1'b0;

    // ---------------- internal mode (u0) ----------------
    st_pie = 1'b1;
    irq_lines = 32'h0000_00A5;
    @(posedge clk);
    push(1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_00A5, "R1 pending mirror");
    @(negedge clk);
    irq_lines = 32'h8000_0100;
    @(posedge clk);
    push(1'b0, 1'b0, 1'b1, 1'b1, 32'h8000_0100, "R1 pending mirror second pattern");
    @(negedge clk);

    irq_lines = 32'h0000_0008;
    try_take(1'b0, 1'b0, 1'b1, "R11 enable cleared by reset, R9 masked still works");
    write_en(1'b0, 32'h0000_0008);
    try_take(1'b0, 1'b0, 1'b1, "R3 data without strobe ignored");
    write_en(1'b1, 32'h0000_0008);
    try_take(1'b0, 1'b1, 1'b1, "R2 enabled pending line taken");
    st_pie = 1'b0;
    try_take(1'b0, 1'b0, 1'b1, "R2 global enable off blocks");
    st_pie = 1'b1;

    write_en(1'b1, 32'h8000_0000);
    irq_lines = 32'h8000_0000;
    try_take(1'b0, 1'b1, 1'b1, "R2 top line taken");
    irq_lines = 32'h4000_0000;
    try_take(1'b0, 1'b0, 1'b1, "R2 line without enable not taken");

    // R10: no boundary means no take; held boundary gives 1,0,1
    irq_lines = 32'h8000_0000;
    repeat (3) @(posedge clk);
    push(1'b0, 1'b0, 1'b1, 1'b0, '0, "R10 no boundary no take");
    @(negedge clk);
    at_boundary = 1'b1;
    @(posedge clk);
    push(1'b0, 1'b1, 1'b1, 1'b0, '0, "R10 first take");
    @(posedge clk);
    push(1'b0, 1'b0, 1'b1, 1'b0, '0, "R10 no back-to-back take");
    @(posedge clk);
    push(1'b0, 1'b1, 1'b1, 1'b0, '0, "R10 take again after gap");
    @(negedge clk);
    at_boundary = 1'b0;

    irq_lines = 32'h0;
    try_take(1'b0, 1'b0, 1'b0, "R9 no lines no work");

    // ---------------- external mode (u1) ----------------
    ext_valid = 1'b1; ext_nmi = 1'b1; ext_level = 6'd0; ext_set = 6'd0;
    st_pie = 1'b0; st_nmi = 1'b0; st_il = 6'd7; st_crs = 6'd0; st_rsie = 1'b0;
    try_take(1'b1, 1'b1, 1'b1, "R4 nmi overrides enable and level");
    st_nmi = 1'b1;
    try_take(1'b1, 1'b0, 1'b1, "R4 nmi blocked in nmi handler");
    st_nmi = 1'b0;

    ext_nmi = 1'b0; ext_level = 6'd10; ext_set = 6'd3; st_il = 6'd2; st_crs = 6'd1;
    try_take(1'b1, 1'b0, 1'b1, "R5 maskable blocked by enable off");
    st_pie = 1'b1;
    st_il = 6'd10;
    try_take(1'b1, 1'b0, 1'b1, "R6 equal level rejected");
    st_il = 6'd9;
    try_take(1'b1, 1'b1, 1'b1, "R6 higher level, R7 other set taken without rsie");
    st_il = 6'd40;
    try_take(1'b1, 1'b0, 1'b1, "R6 lower level rejected");
    st_il = 6'd2;

    ext_set = 6'd1;
    try_take(1'b1, 1'b0, 1'b1, "R8 same set without rsie rejected");
    st_rsie = 1'b1;
    try_take(1'b1, 1'b1, 1'b1, "R8 same set with rsie taken");

    ext_valid = 1'b0;
    try_take(1'b1, 1'b0, 1'b0, "R9 no request no work");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule